// File: doc/BRIEF.md
# Clear-on-Read Event Log Register

This block keeps a word of sticky event flags behind one APB read offset. Each bit of a hardware event-pulse vector sets its own flag, and the flag stays set until software reads it. The log is drained by reading it. A read at the log offset presents every flag on the read-data output. When the read completes, the bits that were presented are cleared, so software sees each event once.

The clear is tied to the transfer's completion and not to the address match. The match is live for the whole access, including every wait state the enclosing slave inserts through PREADY. An event that arrives in the completion cycle survives the clear and is reported by the next read. A registered level interrupt reports that at least one flag is set. Writes to the offset, and accesses to any other address, change nothing. For any address other than the log offset, the read-data contribution is a defined zero, so it can be ORed onto a shared read bus.

Top module: `evlog_cor`

## Requirements
- R1: While reset (active-low) is asserted and on the first cycle after it, all flags are clear, the interrupt is low and a read of the log offset returns 0.
- R2: A 1 on bit i of the event input at a rising edge sets flag i from that edge onward. The flag stays set until a completed read clears it.
- R3: While PSEL is high, PWRITE is low and PADDR equals the log offset, the read-data output equals all 32 flag bits (bit i = flag i), combinationally, in the same cycle.
- R4: Flags are cleared only at an edge where PSEL, PENABLE, PREADY are high, PWRITE is low and PADDR equals the log offset.
- R5: During wait cycles of a read (PSEL and PENABLE high, PREADY low) no flag is cleared, even though the address matches.
- R6: At a completed read, exactly the bits returned in that cycle are cleared, once. The next state is (flags & ~returned) | events.
- R7: An event bit that arrives at the same edge as a clear remains set afterward and is returned by the next read.
- R8: With PADDR other than the log offset, the read-data output is 0 and no flag changes except by events.
- R9: Write transfers to the log offset do not change any flag, and the read-data output is 0 while PWRITE is high.
- R10: The interrupt output is a register that, after each edge, equals the OR of all flags held after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access-phase indicator |
| pwrite | input | 1 | 1 = write, 0 = read |
| pready | input | 1 | Transfer completes when high in the access phase |
| paddr | input | ADDR_W (12) | Byte address |
| ev_pulse | input | DATA_W (32) | Event pulses, one per flag |
| rd_data | output | DATA_W (32) | Read-data contribution, 0 when not addressed |
| irq | output | 1 | Registered level interrupt, high while any flag is set |

## Verification
Read data has no register on its path, so it is due in the cycle the request is presented. The bench checks it one time step after driving the inputs at the falling edge. Flags and the interrupt change at the rising edge that samples an event or a completion. The bench updates its model at that edge and checks the interrupt at the next falling edge. Any effect of a flag change on read data shows up in the next cycle that addresses the log. Reads are issued with zero to several wait cycles, so an early clear shows up as a missing bit at completion.

// File: rtl/evlog_pkg.sv
package evlog_pkg;
  // Phase signals of one bus cycle, grouped for the qualifier.
  typedef struct packed {
    logic sel;
    logic en;
    logic wr;
    logic rdy;
  } bus_phase_t;

  localparam int unsigned EVLOG_DATA_W = 32;
  localparam int unsigned EVLOG_ADDR_W = 12;
endpackage

// File: rtl/evlog_qual.sv
module evlog_qual
  import evlog_pkg::*;
#(
  parameter int unsigned ADDR_W = EVLOG_ADDR_W,
  parameter logic [ADDR_W-1:0] OFFSET = '0
) (
  input  bus_phase_t        ph,
  input  logic [ADDR_W-1:0] paddr,
  output logic              hit_rd,
  output logic              rd_done
);
  logic addr_match;

  assign addr_match = (paddr == OFFSET);
  // The mux may present data during the whole read, setup phase included.
  assign hit_rd     = ph.sel & ~ph.wr & addr_match;
  // The side effect is tied to completion only.
  assign rd_done    = hit_rd & ph.en & ph.rdy;
endmodule

// File: rtl/evlog_flags.sv
module evlog_flags #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] ev,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] flags_q,
  output logic [W-1:0] flags_d
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    // An event wins over a clear landing on the same edge.
    assign flags_d[i] = (flags_q[i] & ~(clr_en & clr_mask[i])) | ev[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags_q[i] <= 1'b0;
      else        flags_q[i] <= flags_d[i];
    end
  end
endmodule

// File: rtl/evlog_irq.sv
module evlog_irq #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags_next,
  output logic         irq
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |flags_next;
  end
endmodule

// File: rtl/evlog_cor.sv
module evlog_cor
  import evlog_pkg::*;
#(
  parameter int unsigned DATA_W = EVLOG_DATA_W,
  parameter int unsigned ADDR_W = EVLOG_ADDR_W,
  parameter logic [ADDR_W-1:0] LOG_OFFSET = ADDR_W'('h010)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic              pready,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] ev_pulse,
  output logic [DATA_W-1:0] rd_data,
  output logic              irq
);
  bus_phase_t        ph;
  logic              hit_rd;
  logic              rd_done;
  logic [DATA_W-1:0] flags_q;
  logic [DATA_W-1:0] flags_d;

  assign ph = '{sel: psel, en: penable, wr: pwrite, rdy: pready};

  evlog_qual #(.ADDR_W(ADDR_W), .OFFSET(LOG_OFFSET)) u_qual (
    .ph      (ph),
    .paddr   (paddr),
    .hit_rd  (hit_rd),
    .rd_done (rd_done)
  );

  // Read mux: a single mapped word, defined zero everywhere else.
  always_comb begin
    if (hit_rd) rd_data = flags_q;
    else        rd_data = '0;
  end

  // The clear mask is exactly what the bus is seeing this cycle.
  evlog_flags #(.W(DATA_W)) u_flags (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (ev_pulse),
    .clr_en   (rd_done),
    .clr_mask (rd_data),
    .flags_q  (flags_q),
    .flags_d  (flags_d)
  );

  evlog_irq #(.W(DATA_W)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .flags_next (flags_d),
    .irq        (irq)
  );
endmodule

// File: rtl/evlog_cor_chk.sv
module evlog_cor_chk #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] LOG_OFFSET = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic              pready,
  input logic [ADDR_W-1:0] paddr,
  input logic [DATA_W-1:0] ev_pulse,
  input logic [DATA_W-1:0] rd_data,
  input logic              irq,
  input logic [DATA_W-1:0] flags_q
);
  logic done_c;
  assign done_c = psel & penable & ~pwrite & pready & (paddr == LOG_OFFSET);

  // R1: reset leaves the interrupt low
  p_reset_quiet_r1: assert property (@(posedge clk) !rst_n |=> !irq);

  // R4: without a completion no flag may drop
  p_clear_needs_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done_c |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R5: wait cycles keep every flag
  p_wait_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (psel & penable & ~pready) |=> ((flags_q & $past(flags_q)) == $past(flags_q)));

  // R6: a completion clears what was returned unless re-set
  p_clear_once_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done_c |=> ((flags_q & $past(rd_data & ~ev_pulse)) == '0));

  // R7: an event is never lost
  p_event_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ev_pulse) |=> ((flags_q & $past(ev_pulse)) == $past(ev_pulse)));

  // R8: other addresses read as zero
  p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (paddr != LOG_OFFSET) |-> (rd_data == '0));

  // R9: write cycles contribute zero
  p_write_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwrite |-> (rd_data == '0));

  // R10: interrupt tracks the held flags
  p_irq_level_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (|flags_q));
endmodule

bind evlog_cor evlog_cor_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .LOG_OFFSET(LOG_OFFSET)
) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .pready(pready), .paddr(paddr), .ev_pulse(ev_pulse), .rd_data(rd_data),
  .irq(irq), .flags_q(flags_q)
);

// File: tb/evlog_cor_tb_top.sv
module evlog_cor_tb_top;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam logic [AW-1:0] OFF = 12'h010;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0, pready = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] ev_pulse = '0;
  logic [DW-1:0] rd_data;
  logic          irq;

  int n_checks = 0;
  int n_errors = 0;
  logic [DW-1:0] m_flags = '0;
  logic          m_irq = 1'b0;
  bit            finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  evlog_cor #(.DATA_W(DW), .ADDR_W(AW), .LOG_OFFSET(OFF)) dut_i (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .pready(pready), .paddr(paddr), .ev_pulse(ev_pulse), .rd_data(rd_data),
    .irq(irq)
  );

  function automatic logic [DW-1:0] exp_rd(logic s, logic w, logic [AW-1:0] a,
                                           logic [DW-1:0] f);
    return (s && !w && a == OFF) ? f : '0;
  endfunction

  function automatic logic [DW-1:0] exp_next(logic [DW-1:0] f, logic done,
                                             logic [DW-1:0] ev);
    return (f & ~(done ? f : '0)) | ev;
  endfunction

  task automatic chk(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] rnd_ev();
    return $urandom & $urandom & $urandom;
  endfunction

  // One bus cycle: drive at falling edge, check read data, model the edge,
  // check the interrupt at the next falling edge.
  task automatic cyc(logic s, logic en, logic w, logic rdy, logic [AW-1:0] a,
                     logic [DW-1:0] ev, string req);
    logic done;
    psel = s; penable = en; pwrite = w; pready = rdy; paddr = a; ev_pulse = ev;
    #1;
    chk(req, rd_data, exp_rd(s, w, a, m_flags));
    done = s && en && !w && rdy && (a == OFF);
    @(posedge clk);
    m_flags = exp_next(m_flags, done, ev);
    m_irq   = |m_flags;
    @(negedge clk);
    chk("R10", {31'b0, irq}, {31'b0, m_irq});
  endtask

  task automatic idle(logic [DW-1:0] ev, string req);
    cyc(1'b0, 1'b0, 1'b0, 1'b0, '0, ev, req);
  endtask

  // Read with a chosen number of wait cycles and an event on every cycle.
  task automatic rd_xfer(logic [AW-1:0] a, int waits, logic [DW-1:0] ev_wait,
                         logic [DW-1:0] ev_done, string req);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, a, ev_wait, req);
    for (int k = 0; k < waits; k++) cyc(1'b1, 1'b1, 1'b0, 1'b0, a, ev_wait, "R5");
    cyc(1'b1, 1'b1, 1'b0, 1'b1, a, ev_done, req);
  endtask

  task automatic wr_xfer(logic [AW-1:0] a, int waits, logic [DW-1:0] ev);
    cyc(1'b1, 1'b0, 1'b1, 1'b0, a, ev, "R9");
    for (int k = 0; k < waits; k++) cyc(1'b1, 1'b1, 1'b1, 1'b0, a, ev, "R9");
    cyc(1'b1, 1'b1, 1'b1, 1'b1, a, ev, "R9");
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    // R1: reset state, with events ignored under reset
    ev_pulse = '1;
    repeat (3) @(negedge clk);
    chk("R1", {31'b0, irq}, 32'd0);
    ev_pulse = '0;
    rst_n = 1'b1;
    cyc(1'b1, 1'b0, 1'b0, 1'b0, OFF, '0, "R1");
    chk("R1", {31'b0, irq}, 32'd0);

    // R2: event sets a sticky bit, R3: full word returned
    idle(32'h8000_0001, "R2");
    idle('0, "R2");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, OFF, '0, "R3");
    chk("R3", rd_data, 32'h8000_0001);

    // R5: long wait with no clear, then R6: completion clears once
    rd_xfer(OFF, 4, '0, '0, "R6");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, OFF, '0, "R6");
    chk("R6", rd_data, 32'h0);

    // R7: event on the completion edge is kept
    idle(32'h0000_00F0, "R2");
    rd_xfer(OFF, 1, '0, 32'h0000_0010, "R7");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, OFF, '0, "R7");
    chk("R7", rd_data, 32'h0000_0010);

    // R8: other address reads zero and clears nothing
    rd_xfer(OFF + 12'h4, 2, '0, '0, "R8");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, OFF, '0, "R8");
    chk("R8", rd_data, 32'h0000_0010);

    // R9: write to the offset is ignored
    wr_xfer(OFF, 1, '0);
    cyc(1'b1, 1'b0, 1'b0, 1'b0, OFF, '0, "R9");
    chk("R9", rd_data, 32'h0000_0010);

    // R4: select with PENABLE low but PREADY high is not a completion
    cyc(1'b1, 1'b0, 1'b0, 1'b1, OFF, '0, "R4");
    cyc(1'b1, 1'b0, 1'b0, 1'b0, OFF, '0, "R4");
    chk("R4", rd_data, 32'h0000_0010);

    // Random mix of transfers, checked against the model every cycle
    for (int t = 0; t < 3000; t++) begin
      int kind = $urandom_range(0, 5);
      int w    = $urandom_range(0, 3);
      case (kind)
        0, 1:    rd_xfer(OFF, w, rnd_ev(), rnd_ev(), "R6");
        2:       rd_xfer(12'($urandom), w, rnd_ev(), rnd_ev(), "R8");
        3:       wr_xfer(($urandom_range(0, 1) == 0) ? OFF : 12'($urandom), w, rnd_ev());
        default: idle(rnd_ev(), "R2");
      endcase
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule